// File: doc/BRIEF.md
# Boot-Time Decode Table Copier

This block sequences a system through power-up. While it runs, a fast RAM is loaded with the contents of a nonvolatile decode table. Once loaded, that RAM serves as the address decoder. For the whole copy the processor is held stopped, the table ROM drives its outputs, and the RAM sits in write mode. Every peripheral data line and every decoded select line is forced inactive, so nothing downstream sees unsettled values.

A phase counter running on the system clock divides time into strobe periods. Each period holds one write strobe to the RAM, placed in the middle of the period. An address counter steps one table location per period. When the address counter wraps past the last location, a one-bit saturating flag sets and stays set. From that edge on, the address counter and ROM are switched off, the RAM turns to read mode, the processor address drives the RAM, and the RAM data becomes the decoded control outputs. The processor is released on that same edge.

Only a reset clears the flag. A reset at any time restarts the copy from location 0. The table length and the strobe period are parameters. They default to 65536 locations and 256 clocks per location.

Top module: `boot_table_copier`

## Requirements
- R1: While reset is held, cpu_en is 0, rom_oe is 1, ram_oe is 0, ram_we is 0 and rom_addr is 0.
- R2: During the copy, rom_addr holds each location for exactly PERIOD clocks. It counts 0, 1, ... DEPTH-1 in order, advancing on the clock edge that ends each period.
- R3: Let phase be the number of clocks since the current location began (0 to PERIOD-1). ram_we is 1 exactly when PERIOD/4 <= phase < PERIOD-PERIOD/4. This gives one pulse per location, DEPTH pulses per copy, with ram_addr unchanged for at least one clock before each rise and after each fall.
- R4: During the copy, ram_addr equals rom_addr and ram_wdata equals rom_data. After a full copy, RAM location a holds the ROM value of location a for every a below DEPTH.
- R5: During the copy, cpu_en is 0, rom_oe is 1 and ram_oe is 0.
- R6: During the copy, dec_ctrl and periph_wdata are all zeros, whatever ram_rdata and periph_wdata_in carry.
- R7: The copy ends exactly DEPTH*PERIOD clock edges after reset is released. On that edge cpu_en becomes 1, and it stays 1 until the next reset. From then on, rom_addr stays 0.
- R8: After the copy, rom_oe is 0, ram_oe is 1 and ram_we is 0. ram_addr follows cpu_addr, dec_ctrl follows ram_rdata, and periph_wdata follows periph_wdata_in, all combinationally.
- R9: A reset asserted at any point, mid-copy or after completion, returns the block to the R1 state at once. After release, the whole copy starts again from location 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rom_addr | output | ADDR_W | Table ROM location being copied |
| rom_data | input | DATA_W | Table ROM data for rom_addr |
| rom_oe | output | 1 | Table ROM output enable, high during the copy |
| ram_addr | output | ADDR_W | Fast RAM address: copy location, then cpu_addr |
| ram_wdata | output | DATA_W | Fast RAM write data during the copy |
| ram_we | output | 1 | Fast RAM write strobe, active high |
| ram_oe | output | 1 | Fast RAM read mode, high after the copy |
| ram_rdata | input | DATA_W | Fast RAM read data |
| cpu_addr | input | ADDR_W | Processor address bus |
| cpu_en | output | 1 | Processor enable, high after the copy |
| dec_ctrl | output | DATA_W | Decoded control/select lines, zero during the copy |
| periph_wdata_in | input | PDATA_W | Peripheral data from the processor |
| periph_wdata | output | PDATA_W | Qualified peripheral data, zero during the copy |

## Verification
The bench counts the clock edges since reset release. After k edges, rom_addr must be k/PERIOD and the phase k mod PERIOD. The strobe is registered, but its value is computed from the next phase, so ram_we must match the window test on the current phase in the same cycle. cpu_en must rise exactly at k = DEPTH*PERIOD. Every output is sampled at the falling clock edge, half a period after the edge that updated it. The run-mode muxes are combinational, so those checks change cpu_addr and read back after a short delay with no clock edge in between. Reset checks are read just after reset is asserted, because the reset is asynchronous.

// File: rtl/bt_pkg.sv
package bt_pkg;

   typedef enum logic {
      BOOT_COPY = 1'b0,
      BOOT_RUN  = 1'b1
   } boot_phase_e;

   // first phase of the write window inside one strobe period
   function automatic int win_lo(input int period);
      return period / 4;
   endfunction

   // first phase after the write window
   function automatic int win_hi(input int period);
      return period - (period / 4);
   endfunction

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/bt_strobe_gen.sv
module bt_strobe_gen
   import bt_pkg::*;
#(
   parameter int PERIOD = 256
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic we,
   output logic tick
);
   localparam int PH_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(PERIOD - 1);
   localparam logic [PH_W-1:0] PH_LO   = PH_W'(win_lo(PERIOD));
   localparam logic [PH_W-1:0] PH_HI   = PH_W'(win_hi(PERIOD));

   if (PERIOD < 4) begin : g_bad_period
      $error("bt_strobe_gen: PERIOD must be at least 4");
   end

   logic [PH_W-1:0] phase_q;
   logic [PH_W-1:0] phase_nxt;
   logic            we_q;

   assign tick = en && (phase_q == PH_LAST);

   if (is_pow2(PERIOD)) begin : g_wrap_free
      // counter width matches the period, so it rolls over by itself
      always_comb begin
         phase_nxt = phase_q;
         if (en) phase_nxt = phase_q + 1'b1;
      end
   end else begin : g_wrap_cmp
      always_comb begin
         phase_nxt = phase_q;
         if (en) begin
            if (phase_q == PH_LAST) phase_nxt = '0;
            else                    phase_nxt = phase_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
         we_q    <= 1'b0;
      end else begin
         phase_q <= phase_nxt;
         // registered from the next phase: glitch free, aligned with phase_q
         we_q    <= en && (phase_nxt >= PH_LO) && (phase_nxt < PH_HI);
      end
   end

   assign we = we_q;

endmodule

// File: rtl/bt_addr_seq.sv
module bt_addr_seq #(
   parameter int ADDR_W = 16,
   parameter int DEPTH  = 65536
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              step,
   output logic [ADDR_W-1:0] addr,
   output logic              wrap
);
   localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

   if (DEPTH < 2) begin : g_bad_depth_lo
      $error("bt_addr_seq: DEPTH must be at least 2");
   end
   if (DEPTH > (2 ** ADDR_W)) begin : g_bad_depth_hi
      $error("bt_addr_seq: DEPTH exceeds the address range");
   end

   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] addr_nxt;

   if (DEPTH == (2 ** ADDR_W)) begin : g_full_range
      assign wrap = en && step && (&addr_q);
      always_comb begin
         addr_nxt = addr_q;
         if (en && step) addr_nxt = addr_q + 1'b1;
      end
   end else begin : g_part_range
      assign wrap = en && step && (addr_q == LAST);
      always_comb begin
         addr_nxt = addr_q;
         if (en && step) begin
            if (addr_q == LAST) addr_nxt = '0;
            else                addr_nxt = addr_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) addr_q <= '0;
      else        addr_q <= addr_nxt;
   end

   assign addr = addr_q;

endmodule

// File: rtl/bt_sat_flag.sv
module bt_sat_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   output logic flag
);
   logic flag_q;

   // one-bit saturating counter: counts to 1 and stays there
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   flag_q <= 1'b0;
      else if (set) flag_q <= 1'b1;
   end

   assign flag = flag_q;

endmodule

// File: rtl/boot_table_copier.sv
module boot_table_copier
   import bt_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 8,
   parameter int PDATA_W = 8,
   parameter int DEPTH   = 2 ** ADDR_W,
   parameter int PERIOD  = 256
) (
   input  logic               clk,
   input  logic               rst_n,
   output logic [ADDR_W-1:0]  rom_addr,
   input  logic [DATA_W-1:0]  rom_data,
   output logic               rom_oe,
   output logic [ADDR_W-1:0]  ram_addr,
   output logic [DATA_W-1:0]  ram_wdata,
   output logic               ram_we,
   output logic               ram_oe,
   input  logic [DATA_W-1:0]  ram_rdata,
   input  logic [ADDR_W-1:0]  cpu_addr,
   output logic               cpu_en,
   output logic [DATA_W-1:0]  dec_ctrl,
   input  logic [PDATA_W-1:0] periph_wdata_in,
   output logic [PDATA_W-1:0] periph_wdata
);
   if (ADDR_W < 1 || DATA_W < 1 || PDATA_W < 1) begin : g_bad_width
      $error("boot_table_copier: widths must be positive");
   end

   logic        copy_en;
   logic        strobe;
   logic        period_end;
   logic        last_wrap;
   logic        done;
   logic [ADDR_W-1:0] seq_addr;
   boot_phase_e mode;

   assign mode    = done ? BOOT_RUN : BOOT_COPY;
   assign copy_en = (mode == BOOT_COPY);

   bt_strobe_gen #(
      .PERIOD (PERIOD)
   ) i_strobe (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (copy_en),
      .we    (strobe),
      .tick  (period_end)
   );

   bt_addr_seq #(
      .ADDR_W (ADDR_W),
      .DEPTH  (DEPTH)
   ) i_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (copy_en),
      .step  (period_end),
      .addr  (seq_addr),
      .wrap  (last_wrap)
   );

   bt_sat_flag i_done (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (last_wrap),
      .flag  (done)
   );

   // one phase signal steers every qualified output together
   always_comb begin
      rom_addr     = seq_addr;
      rom_oe       = 1'b1;
      ram_oe       = 1'b0;
      ram_we       = strobe;
      ram_addr     = seq_addr;
      ram_wdata    = rom_data;
      cpu_en       = 1'b0;
      dec_ctrl     = '0;
      periph_wdata = '0;
      if (mode == BOOT_RUN) begin
         rom_oe       = 1'b0;
         ram_oe       = 1'b1;
         ram_we       = 1'b0;
         ram_addr     = cpu_addr;
         ram_wdata    = '0;
         cpu_en       = 1'b1;
         dec_ctrl     = ram_rdata;
         periph_wdata = periph_wdata_in;
      end
   end

endmodule

// File: rtl/bt_copier_checker.sv
module bt_copier_checker #(
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 8,
   parameter int PDATA_W = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cpu_en,
   input logic               rom_oe,
   input logic               ram_oe,
   input logic               ram_we,
   input logic [ADDR_W-1:0]  rom_addr,
   input logic [ADDR_W-1:0]  ram_addr,
   input logic [DATA_W-1:0]  dec_ctrl,
   input logic [PDATA_W-1:0] periph_wdata
);

   assert_reset_state_R1: assert property (@(posedge clk)
      (!rst_n) |=> (!cpu_en && rom_oe && !ram_oe && !ram_we && rom_addr == '0));

   assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_en && rom_addr != $past(rom_addr))
         |-> (rom_addr == ADDR_W'($past(rom_addr) + 1'b1) || rom_addr == '0));

   assert_setup_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ram_we) |-> $stable(ram_addr));

   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ram_we) |-> $stable(ram_addr));

   assert_copy_modes_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_en) |-> (rom_oe && !ram_oe));

   assert_qualified_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_en) |-> (dec_ctrl == '0 && periph_wdata == '0));

   assert_saturate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cpu_en) |-> (cpu_en && rom_addr == '0));

   assert_run_modes_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_en |-> (!ram_we && !rom_oe && ram_oe));

endmodule

bind boot_table_copier bt_copier_checker #(
   .ADDR_W  (ADDR_W),
   .DATA_W  (DATA_W),
   .PDATA_W (PDATA_W)
) i_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .cpu_en       (cpu_en),
   .rom_oe       (rom_oe),
   .ram_oe       (ram_oe),
   .ram_we       (ram_we),
   .rom_addr     (rom_addr),
   .ram_addr     (ram_addr),
   .dec_ctrl     (dec_ctrl),
   .periph_wdata (periph_wdata)
);

// File: tb/test_boot_table_copier.sv
module test_boot_table_copier;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W  = 4;
   localparam int DATA_W  = 8;
   localparam int PDATA_W = 8;
   localparam int DEPTH   = 12;
   localparam int PERIOD  = 6;
   localparam int TOTAL   = DEPTH * PERIOD;
   localparam int W_LO    = PERIOD / 4;
   localparam int W_HI    = PERIOD - PERIOD / 4;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [ADDR_W-1:0]  rom_addr;
   logic [DATA_W-1:0]  rom_data;
   logic               rom_oe;
   logic [ADDR_W-1:0]  ram_addr;
   logic [DATA_W-1:0]  ram_wdata;
   logic               ram_we;
   logic               ram_oe;
   logic [DATA_W-1:0]  ram_rdata;
   logic [ADDR_W-1:0]  cpu_addr = 4'd3;
   logic               cpu_en;
   logic [DATA_W-1:0]  dec_ctrl;
   logic [PDATA_W-1:0] periph_wdata_in = 8'hA5;
   logic [PDATA_W-1:0] periph_wdata;

   logic [DATA_W-1:0]  mem [DEPTH];
   int checks = 0;
   int errors = 0;
   int pulses;
   logic prev_we;

   function automatic logic [DATA_W-1:0] tbl(input int a);
      return DATA_W'(a * 29 + 7);
   endfunction

   assign rom_data  = tbl(int'(rom_addr));
   assign ram_rdata = (int'(ram_addr) < DEPTH) ? mem[ram_addr] : 8'h00;

   always #(CLK_PERIOD / 2) clk = ~clk;

   always @(negedge clk) begin
      if (ram_we && int'(ram_addr) < DEPTH) mem[ram_addr] <= ram_wdata;
   end

   boot_table_copier #(
      .ADDR_W (ADDR_W), .DATA_W (DATA_W), .PDATA_W (PDATA_W),
      .DEPTH (DEPTH), .PERIOD (PERIOD)
   ) i_boot_table_copier (
      .clk (clk), .rst_n (rst_n),
      .rom_addr (rom_addr), .rom_data (rom_data), .rom_oe (rom_oe),
      .ram_addr (ram_addr), .ram_wdata (ram_wdata), .ram_we (ram_we),
      .ram_oe (ram_oe), .ram_rdata (ram_rdata), .cpu_addr (cpu_addr),
      .cpu_en (cpu_en), .dec_ctrl (dec_ctrl),
      .periph_wdata_in (periph_wdata_in), .periph_wdata (periph_wdata)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic check_reset_state(input string tag);
      check({tag, " R1 cpu_en"}, 32'(cpu_en), 0);
      check({tag, " R1 rom_oe"}, 32'(rom_oe), 1);
      check({tag, " R1 ram_oe"}, 32'(ram_oe), 0);
      check({tag, " R1 ram_we"}, 32'(ram_we), 0);
      check({tag, " R1 rom_addr"}, 32'(rom_addr), 0);
   endtask

   task automatic clear_mem();
      for (int a = 0; a < DEPTH; a++) mem[a] = 8'hEE;
   endtask

   // called right after reset release at a falling edge: k edges seen so far
   task automatic run_copy(input int ncyc, input bit full);
      pulses  = 0;
      prev_we = 1'b0;
      for (int k = 0; k <= ncyc; k++) begin
         bit done_e = (k >= TOTAL);
         int ph = k % PERIOD;
         int a  = done_e ? 0 : k / PERIOD;
         bit we_e = !done_e && ph >= W_LO && ph < W_HI;
         check("R2 rom_addr", 32'(rom_addr), 32'(a));
         check("R3 ram_we", 32'(ram_we), 32'(we_e));
         check("R7 cpu_en", 32'(cpu_en), 32'(done_e));
         if (!done_e) begin
            check("R4 ram_addr", 32'(ram_addr), 32'(a));
            check("R4 ram_wdata", 32'(ram_wdata), 32'(tbl(a)));
            check("R5 rom_oe", 32'(rom_oe), 1);
            check("R5 ram_oe", 32'(ram_oe), 0);
            check("R6 dec_ctrl", 32'(dec_ctrl), 0);
            check("R6 periph_wdata", 32'(periph_wdata), 0);
         end
         if (ram_we && !prev_we) pulses++;
         prev_we = ram_we;
         @(negedge clk);
      end
      if (full) begin
         check("R3 pulse count", 32'(pulses), 32'(DEPTH));
         for (int a = 0; a < DEPTH; a++)
            check("R4 ram content", 32'(mem[a]), 32'(tbl(a)));
      end
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      clear_mem();
      repeat (3) @(negedge clk);
      check_reset_state("held reset");
      rst_n = 1'b1;

      // first full copy, then run mode
      run_copy(TOTAL + 3, 1'b1);
      check("R8 rom_oe", 32'(rom_oe), 0);
      check("R8 ram_oe", 32'(ram_oe), 1);
      check("R8 ram_we", 32'(ram_we), 0);
      for (int a = 0; a < DEPTH; a++) begin
         cpu_addr = ADDR_W'(a);
         periph_wdata_in = 8'(a * 3 + 1);
         #1;
         check("R8 ram_addr", 32'(ram_addr), 32'(a));
         check("R8 dec_ctrl", 32'(dec_ctrl), 32'(tbl(a)));
         check("R8 periph_wdata", 32'(periph_wdata), 32'(a * 3 + 1));
      end
      cpu_addr = 4'd3;
      periph_wdata_in = 8'hA5;
      repeat (25) @(negedge clk);
      check("R7 stays done", 32'(cpu_en), 1);
      check("R7 rom_addr parked", 32'(rom_addr), 0);

      // reset in run mode
      rst_n = 1'b0;
      #1;
      check_reset_state("R9 reset after done");
      clear_mem();
      repeat (2) @(negedge clk);
      rst_n = 1'b1;

      // partial copy, then reset mid-copy
      run_copy(PERIOD * 4 + 2, 1'b0);
      rst_n = 1'b0;
      #1;
      check_reset_state("R9 reset mid-copy");
      clear_mem();
      @(negedge clk);
      rst_n = 1'b1;

      // second full copy from location 0
      run_copy(TOTAL + 2, 1'b1);
      check("R9 restarted copy done", 32'(cpu_en), 1);

      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule